// File: doc/BRIEF.md
# Memory Port Bridge with Completion Handshake

This block sits between a processor's single internal data bus and an external memory bus. It holds two registers. The address register loads from the internal bus and drives the memory address lines. The data register can load from the internal bus or from the memory read-data lines, and its contents can drive the internal bus, the memory write-data lines, or both. Control issues a read or write command. The block raises the matching request line and holds it until memory answers with a one-cycle done pulse.

While a request is outstanding and the done pulse has not arrived, a stall output tells the control step counter to hold. The transfer sequencer is a three-state machine. `XF_IDLE` moves to `XF_READ` on a lone read command and to `XF_WRITE` on a lone write command. It stays in `XF_IDLE` when neither command is present or when both arrive together. `XF_READ` and `XF_WRITE` return to `XF_IDLE` on the edge where `mem_done` is high. A command that arrives while a transfer is outstanding is dropped, and a sticky error flag is raised. The flag is cleared only by reset.

Top module: `memif_bridge`

## Requirements
- R1: After reset, `mem_rd`, `mem_wr`, `wait_o` and `cmd_err` are 0, and both the address register (`mem_addr`) and the data register (`ibus_out`) are 0.
- R2: When `addr_load` is 1 at a clock edge, `mem_addr` takes `ibus_in[ADDR_W-1:0]` from the next cycle. When `addr_load` is 0, `mem_addr` holds its value.
- R3: When `mdr_load_int` is 1 at a clock edge, the data register takes `ibus_in`. `ibus_out` always shows the data register, and `ibus_drive` equals `mdr_drive_int`.
- R4: A lone `rd_cmd` in the idle state makes `mem_rd` 1 from the next cycle. `mem_rd` stays 1 through the cycle in which `mem_done` is 1 and is 0 in the cycle after that.
- R5: In the cycle where `mem_done` is 1 during a read, the data register captures `mem_rdata` if `mdr_load_ext` is 1. If `mdr_load_ext` is 0, the data register keeps its value.
- R6: If the read capture of R5 and `mdr_load_int` fall on the same edge, the memory data wins.
- R7: A lone `wr_cmd` in the idle state drives `mem_wr` with the same timing as R4. `mem_wdata` always shows the data register, and `mem_wdata_oe` equals `mdr_drive_ext`.
- R8: `wait_o` is 1 exactly when `mem_rd` or `mem_wr` is 1 and `mem_done` is 0. A transfer whose memory needs L cycles therefore stalls for L cycles.
- R9: A `rd_cmd` or `wr_cmd` seen while a transfer is outstanding does not change the request lines. This includes the cycle in which `mem_done` arrives. Such a command sets `cmd_err` to 1, and `cmd_err` stays 1 until reset.
- R10: `rd_cmd` and `wr_cmd` together in the idle state start no transfer and set `cmd_err`. `mem_rd` and `mem_wr` are never 1 together.
- R11: `mem_done` in the idle state has no effect. No request starts, and the data register is unchanged even when `mdr_load_ext` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ibus_in | input | DATA_W | Value on the internal bus |
| ibus_out | output | DATA_W | Data register contents toward the internal bus |
| ibus_drive | output | 1 | Data register is driving the internal bus |
| addr_load | input | 1 | Load the address register from the internal bus |
| mdr_load_int | input | 1 | Load the data register from the internal bus |
| mdr_load_ext | input | 1 | Allow the data register to capture read data at completion |
| mdr_drive_int | input | 1 | Gate the data register onto the internal bus |
| mdr_drive_ext | input | 1 | Gate the data register onto the memory write-data lines |
| rd_cmd | input | 1 | Read command from control |
| wr_cmd | input | 1 | Write command from control |
| wait_o | output | 1 | Stall the control step counter |
| cmd_err | output | 1 | Sticky flag for a dropped command |
| mem_addr | output | ADDR_W | Memory address lines |
| mem_wdata | output | DATA_W | Memory write-data lines |
| mem_wdata_oe | output | 1 | Write-data lines are driven |
| mem_rdata | input | DATA_W | Memory read-data lines |
| mem_rd | output | 1 | Read request |
| mem_wr | output | 1 | Write request |
| mem_done | input | 1 | Memory function completed |

## Verification
Two events can fall on the same edge: the memory-side capture of read data and an internal-bus load of the data register. The bench provokes this by raising `mdr_load_int`, with a different value on `ibus_in`, in exactly the sample where the stall has just dropped while `mem_rd` is still high. The scoreboard then expects the memory word and not the bus word. A second collision puts a fresh write command into that same completion cycle. The bench judges it by checking that `mem_wr` stays low in the following cycle and that `cmd_err` is set.

// File: rtl/memif_pkg.sv
package memif_pkg;

    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_READ  = 2'd1,
        XF_WRITE = 2'd2
    } xfer_state_t;

endpackage

// File: rtl/memif_addr_reg.sv
module memif_addr_reg #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] bus_in,
    output logic [ADDR_W-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (load) begin
            addr_q <= bus_in[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/memif_data_reg.sv
module memif_data_reg #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_int,
    input  logic              load_ext,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] mem_in,
    output logic [DATA_W-1:0] data_q
);

    // Memory-side capture outranks the internal-bus load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (load_ext) begin
            data_q <= mem_in;
        end else if (load_int) begin
            data_q <= bus_in;
        end
    end

endmodule

// File: rtl/memif_xfer_fsm.sv
module memif_xfer_fsm
    import memif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_cmd,
    input  logic wr_cmd,
    input  logic mem_done,
    output logic mem_rd,
    output logic mem_wr,
    output logic stall,
    output logic capture_ok,
    output logic cmd_err
);

    xfer_state_t state_q;
    xfer_state_t state_nxt;
    logic        bad_cmd;
    logic        err_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // Sticky error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (bad_cmd) begin
            err_q <= 1'b1;
        end
    end

    // Transitions
    always_comb begin
        state_nxt = state_q;
        bad_cmd   = 1'b0;
        unique case (state_q)
            XF_IDLE: begin
                if (rd_cmd && wr_cmd) begin
                    bad_cmd = 1'b1;
                end else if (rd_cmd) begin
                    state_nxt = XF_READ;
                end else if (wr_cmd) begin
                    state_nxt = XF_WRITE;
                end
            end
            XF_READ, XF_WRITE: begin
                if (rd_cmd || wr_cmd) begin
                    bad_cmd = 1'b1;
                end
                if (mem_done) begin
                    state_nxt = XF_IDLE;
                end
            end
            default: begin
                state_nxt = XF_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        mem_rd     = 1'b0;
        mem_wr     = 1'b0;
        stall      = 1'b0;
        capture_ok = 1'b0;
        unique case (state_q)
            XF_IDLE: begin
            end
            XF_READ: begin
                mem_rd     = 1'b1;
                stall      = !mem_done;
                capture_ok = mem_done;
            end
            XF_WRITE: begin
                mem_wr = 1'b1;
                stall  = !mem_done;
            end
            default: begin
            end
        endcase
    end

    assign cmd_err = err_q;

endmodule

// File: rtl/memif_bridge.sv
module memif_bridge #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] ibus_in,
    output logic [DATA_W-1:0] ibus_out,
    output logic              ibus_drive,
    input  logic              addr_load,
    input  logic              mdr_load_int,
    input  logic              mdr_load_ext,
    input  logic              mdr_drive_int,
    input  logic              mdr_drive_ext,
    input  logic              rd_cmd,
    input  logic              wr_cmd,
    output logic              wait_o,
    output logic              cmd_err,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_wdata_oe,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_done
);

    logic              capture_ok;
    logic [DATA_W-1:0] mdr_q;

    memif_xfer_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (rd_cmd),
        .wr_cmd     (wr_cmd),
        .mem_done   (mem_done),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .stall      (wait_o),
        .capture_ok (capture_ok),
        .cmd_err    (cmd_err)
    );

    memif_addr_reg #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_mar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (addr_load),
        .bus_in (ibus_in),
        .addr_q (mem_addr)
    );

    memif_data_reg #(
        .DATA_W (DATA_W)
    ) u_mdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_int (mdr_load_int),
        .load_ext (capture_ok && mdr_load_ext),
        .bus_in   (ibus_in),
        .mem_in   (mem_rdata),
        .data_q   (mdr_q)
    );

    assign ibus_out     = mdr_q;
    assign ibus_drive   = mdr_drive_int;
    assign mem_wdata    = mdr_q;
    assign mem_wdata_oe = mdr_drive_ext;

endmodule

// File: rtl/memif_bridge_chk.sv
module memif_bridge_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] ibus_in,
    input logic [DATA_W-1:0] ibus_out,
    input logic              addr_load,
    input logic              mdr_load_ext,
    input logic              rd_cmd,
    input logic              wr_cmd,
    input logic              wait_o,
    input logic              cmd_err,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_rdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              mem_done
);

    // R10
    rw_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R4
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_done) |=> mem_rd);

    // R4
    rd_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_done) |=> !mem_rd);

    // R7
    wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_done) |=> !mem_wr);

    // R8
    wait_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && !mem_done) |-> wait_o);

    // R8
    wait_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !mem_wr) |-> !wait_o);

    // R2
    mar_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_load |=> (mem_addr == $past(ibus_in[ADDR_W-1:0])));

    // R5
    rd_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && mem_done && mdr_load_ext) |=> (ibus_out == $past(mem_rdata)));

    // R9
    busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mem_rd || mem_wr) && (rd_cmd || wr_cmd)) |=> cmd_err);

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> cmd_err);

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_rd && !mem_wr && !rd_cmd && !wr_cmd) |=> (!mem_rd && !mem_wr));

endmodule

bind memif_bridge memif_bridge_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ibus_in      (ibus_in),
    .ibus_out     (ibus_out),
    .addr_load    (addr_load),
    .mdr_load_ext (mdr_load_ext),
    .rd_cmd       (rd_cmd),
    .wr_cmd       (wr_cmd),
    .wait_o       (wait_o),
    .cmd_err      (cmd_err),
    .mem_addr     (mem_addr),
    .mem_rdata    (mem_rdata),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .mem_done     (mem_done)
);

// File: tb/memif_bridge_bench.sv
`timescale 1ns/1ps
module memif_bridge_bench;

    localparam int DW = 16;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] ibus_in = '0;
    logic [DW-1:0] ibus_out;
    logic          ibus_drive;
    logic          addr_load = 1'b0;
    logic          mdr_load_int = 1'b0;
    logic          mdr_load_ext = 1'b0;
    logic          mdr_drive_int = 1'b0;
    logic          mdr_drive_ext = 1'b0;
    logic          rd_cmd = 1'b0;
    logic          wr_cmd = 1'b0;
    logic          wait_o;
    logic          cmd_err;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_wdata_oe;
    logic [DW-1:0] mem_rdata;
    logic          mem_rd;
    logic          mem_wr;
    logic          mem_done;

    // memory model
    logic          m_done = 1'b0;
    logic [DW-1:0] m_rdata = '0;
    logic          x_done = 1'b0;
    logic [DW-1:0] x_rdata = '0;
    int            lat_cfg = 0;
    int            m_cnt = 0;
    logic [DW-1:0] mem_arr [16];
    logic [DW-1:0] exp_arr [16];

    assign mem_done  = m_done | x_done;
    assign mem_rdata = x_done ? x_rdata : m_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [DW-1:0] mdr_shadow = '0;
    logic [DW-1:0] sb_val [$];
    string         sb_tag [$];

    always #2.5 clk = ~clk;

    memif_bridge #(.DATA_W(DW), .ADDR_W(AW)) u_memif_bridge (
        .clk(clk), .rst_n(rst_n), .ibus_in(ibus_in), .ibus_out(ibus_out),
        .ibus_drive(ibus_drive), .addr_load(addr_load),
        .mdr_load_int(mdr_load_int), .mdr_load_ext(mdr_load_ext),
        .mdr_drive_int(mdr_drive_int), .mdr_drive_ext(mdr_drive_ext),
        .rd_cmd(rd_cmd), .wr_cmd(wr_cmd), .wait_o(wait_o), .cmd_err(cmd_err),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_done(mem_done)
    );

    always @(negedge clk) begin
        if (!rst_n) begin
            m_done <= 1'b0;
            m_cnt  <= 0;
        end else if ((mem_rd || mem_wr) && !m_done) begin
            if (m_cnt == lat_cfg) begin
                m_done  <= 1'b1;
                m_rdata <= mem_arr[mem_addr[3:0]];
                if (mem_wr && mem_wdata_oe) mem_arr[mem_addr[3:0]] <= mem_wdata;
                m_cnt   <= 0;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end else begin
            m_done <= 1'b0;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected data register values whenever it drives the bus
    always begin
        @(negedge clk);
        #2;
        if (rst_n && ibus_drive) begin
            if (sb_val.size() == 0) begin
                check("R3 unexpected bus drive", 32'(ibus_out), 32'hdead);
            end else begin
                check(sb_tag.pop_front(), 32'(ibus_out), 32'(sb_val.pop_front()));
            end
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic push_and_show(input string tag);
        sb_val.push_back(mdr_shadow);
        sb_tag.push_back(tag);
        mdr_drive_int = 1'b1;
        step();
        mdr_drive_int = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
        mdr_shadow = '0;
        step();
    endtask

    // mode 0 plain, 1 internal load at completion, 2 write cmd at completion,
    // 3 write cmd in first stall cycle
    task automatic do_read(input logic [DW-1:0] a, input int lat, input bit cap,
                           input int mode, input logic [DW-1:0] alt, input string tag);
        int waited;
        lat_cfg = lat;
        ibus_in = a;
        addr_load = 1'b1;
        rd_cmd = 1'b1;
        mdr_load_ext = cap;
        step();
        addr_load = 1'b0;
        rd_cmd = 1'b0;
        check("R4 rd raised", mem_rd, 1);
        check("R2 addr loaded", mem_addr, a);
        check("R7 wdata lines idle on read", mem_wdata_oe, 0);
        waited = 0;
        while (wait_o && waited < 50) begin
            if (mode == 3 && waited == 0) wr_cmd = 1'b1;
            step();
            wr_cmd = 1'b0;
            waited++;
            check("R4 rd held", mem_rd, 1);
            if (mode == 3 && waited == 1) begin
                check("R9 busy wr ignored", mem_wr, 0);
                check("R9 err set", cmd_err, 1);
            end
        end
        check("R8 stall length", waited, lat);
        check("R8 stall ends with done", mem_done, 1);
        if (mode == 1) begin
            mdr_load_int = 1'b1;
            ibus_in = alt;
        end
        if (mode == 2) wr_cmd = 1'b1;
        if (cap) mdr_shadow = exp_arr[a[3:0]];
        step();
        mdr_load_int = 1'b0;
        mdr_load_ext = 1'b0;
        wr_cmd = 1'b0;
        check("R4 rd dropped", mem_rd, 0);
        if (mode == 2) begin
            check("R9 wr at done ignored", mem_wr, 0);
            check("R9 err at done", cmd_err, 1);
        end
        push_and_show(tag);
    endtask

    task automatic do_write(input logic [DW-1:0] a, input logic [DW-1:0] d, input int lat);
        int waited;
        lat_cfg = lat;
        ibus_in = d;
        mdr_load_int = 1'b1;
        step();
        mdr_load_int = 1'b0;
        mdr_shadow = d;
        ibus_in = a;
        addr_load = 1'b1;
        wr_cmd = 1'b1;
        mdr_drive_ext = 1'b1;
        step();
        addr_load = 1'b0;
        wr_cmd = 1'b0;
        check("R7 wr raised", mem_wr, 1);
        check("R10 no rd on write", mem_rd, 0);
        check("R7 wdata", mem_wdata, d);
        check("R7 wdata oe", mem_wdata_oe, 1);
        waited = 0;
        while (wait_o && waited < 50) begin
            step();
            waited++;
            check("R7 wr held", mem_wr, 1);
        end
        check("R8 write stall length", waited, lat);
        step();
        mdr_drive_ext = 1'b0;
        check("R7 wr dropped", mem_wr, 0);
        exp_arr[a[3:0]] = d;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_arr[i] = 16'hA000 + 16'(i * 37);
            exp_arr[i] = 16'hA000 + 16'(i * 37);
        end
        step();
        step();
        check("R1 rd", mem_rd, 0);
        check("R1 wr", mem_wr, 0);
        check("R1 wait", wait_o, 0);
        check("R1 err", cmd_err, 0);
        check("R1 addr", mem_addr, 0);
        check("R1 data", ibus_out, 0);
        rst_n = 1'b1;
        step();

        // R2 load then hold
        ibus_in = 16'h0003;
        addr_load = 1'b1;
        step();
        addr_load = 1'b0;
        ibus_in = 16'h7777;
        step();
        check("R2 addr hold", mem_addr, 16'h0003);

        // R3 internal load and bus drive
        ibus_in = 16'h5A5A;
        mdr_load_int = 1'b1;
        step();
        mdr_load_int = 1'b0;
        mdr_shadow = 16'h5A5A;
        check("R3 no drive", ibus_drive, 0);
        push_and_show("R3 internal load");

        // R4 R5 R8 reads with several latencies
        do_read(16'h0002, 0, 1'b1, 0, '0, "R5 read lat0");
        do_read(16'h0005, 1, 1'b1, 0, '0, "R5 read lat1");
        do_read(16'h000B, 3, 1'b1, 0, '0, "R5 read lat3");
        do_read(16'h000F, 6, 1'b1, 0, '0, "R5 read lat6");
        do_read(16'h0004, 2, 1'b0, 0, '0, "R5 no capture keeps value");

        // R7 write then read back
        do_write(16'h0006, 16'hBEEF, 2);
        do_read(16'h0006, 1, 1'b1, 0, '0, "R7 write read back");
        do_write(16'h0009, 16'h1234, 0);
        do_read(16'h0009, 4, 1'b1, 0, '0, "R7 write read back lat0");

        // R6 capture beats internal load
        do_read(16'h0001, 2, 1'b1, 1, 16'h4444, "R6 capture priority");
        check("R6 err untouched", cmd_err, 0);

        // R11 done while idle
        mdr_load_ext = 1'b1;
        x_rdata = 16'hCAFE;
        x_done = 1'b1;
        step();
        x_done = 1'b0;
        mdr_load_ext = 1'b0;
        check("R11 no rd", mem_rd, 0);
        check("R11 no wr", mem_wr, 0);
        check("R11 no wait", wait_o, 0);
        push_and_show("R11 idle done ignored");

        // R9 command during stall
        do_read(16'h0007, 3, 1'b1, 3, '0, "R9 read survives busy cmd");
        step();
        check("R9 err sticky", cmd_err, 1);
        do_reset();
        check("R1 err cleared", cmd_err, 0);
        check("R1 data cleared", ibus_out, 0);

        // R9 command in completion cycle
        do_read(16'h0008, 2, 1'b1, 2, '0, "R9 read with cmd at done");
        do_reset();

        // R10 both commands together
        rd_cmd = 1'b1;
        wr_cmd = 1'b1;
        step();
        rd_cmd = 1'b0;
        wr_cmd = 1'b0;
        check("R10 no rd", mem_rd, 0);
        check("R10 no wr", mem_wr, 0);
        check("R10 err", cmd_err, 1);

        step();
        step();
        check("R3 scoreboard drained", sb_val.size(), 0);
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R4 watchdog act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule